// File: doc/BRIEF.md
# Floating-Point Exception Cause and Trap Controller

This block sits beside a floating-point datapath and turns the status of each operation into architectural exception state. When an operation issues, the block takes the operation's raw status flags and its invalid and divide-by-zero strobes. It also takes the processor's FPU-enable bit and a strobe that flags an unimplemented opcode. From these it forms a fresh five-bit cause field, gated by a matching five-bit enable field. It tells the datapath whether the result may be written and whether a quiet NaN must be written in its place.

When a trap is due, the block picks one of three vector codes and sends a one-cycle trap request. It then runs the trap entry on its own. It pushes the PC and the PSW onto the stack through a small write port. After that it hands the processor a new stack pointer, a PSW with interrupts masked, and the fixed handler address. Software reads and writes the enable and cause fields over a one-word register port.

Top module: `fpu_trap_ctrl`

## Requirements
- R1: Every accepted arithmetic operation (`op_valid`, FPU enabled, opcode implemented) replaces the whole cause field with causes from that operation alone, so no cause survives from an earlier operation. Cause bit positions: 4=V (invalid), 3=Z (divide by zero), 2=O (overflow), 1=U (underflow), 0=I (inexact).
- R2: Raw status bit positions: 0=overflow, 1=underflow, 2=denormal, 3=inexact, 4=rounded. Enabled overflow records O. Failing that, enabled underflow or denormal records U. Failing that, enabled inexact or rounded records I. A disabled kind falls through to the next one. At most one of O, U and I is ever recorded.
- R3: `res_we` is high in the cycle of an accepted arithmetic operation exactly when that operation records no cause.
- R4: The invalid strobe takes precedence over all other inputs. It records V when V is enabled. Otherwise the result is written with `res_qnan` high. When the invalid strobe is low, an enabled divide-by-zero records Z; a disabled one falls through to the status reduction of R2.
- R5: An arithmetic operation that records any cause raises a trap with code 0x1d0.
- R6: An operation issued with `fpu_en` low traps with code 0x1c0, even if the opcode is also unimplemented. An unimplemented opcode issued with `fpu_en` high traps with code 0x1c8. Neither case changes the cause field or writes a result.
- R7: Trap entry takes three cycles after the trap edge. First comes a 32-bit write of the PC to SP-4, then a 16-bit write of the PSW to SP-8. Last comes one `arch_we` cycle carrying SP-8, the PSW with bit `IE_BIT` (11) cleared, and PC 0x40000008.
- R8: `trap_req` is high for exactly one cycle per trap. `trap_code` holds the code from that edge until `trap_ack` is sampled, and then returns to 0.
- R9: While trap entry is under way, `op_valid` is ignored: no result write, no cause change and no new trap.
- R10: An accepted arithmetic operation with any raw status bit at position 5 or above set pulses `internal_err` for one cycle. Those bits take no part in the cause reduction.
- R11: After reset, the enable and cause fields read 0 and `trap_req`, `trap_code`, `mem_we`, `arch_we` and `internal_err` are 0. `reg_sel` 0 selects the enable field and 1 selects the cause field. A register write and an accepted operation on the same edge: the operation sets the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | One floating-point operation issues this cycle |
| fpu_en | input | 1 | FPU-enable bit of the PSW |
| unimpl_op | input | 1 | Issued opcode is not implemented |
| raw_status | input | STAT_W | Raw status flags of the operation |
| invalid_op | input | 1 | Operation has invalid operands |
| div_zero | input | 1 | Operation divides a number by zero |
| res_we | output | 1 | Result may be written to the destination |
| res_qnan | output | 1 | Result write carries a quiet NaN |
| reg_we | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0 selects the enable field, 1 the cause field |
| reg_wdata | input | 5 | Register port write data |
| reg_rdata | output | 5 | Register port read data |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Trap vector code, held until acknowledged |
| trap_ack | input | 1 | Trap acknowledge |
| internal_err | output | 1 | Unknown raw status bit seen |
| pc_in | input | ADDR_W | Current PC |
| sp_in | input | ADDR_W | Current stack pointer |
| psw_in | input | PSW_W | Current PSW |
| mem_we | output | 1 | Stack write strobe |
| mem_word | output | 1 | 1: 32-bit write, 0: 16-bit write |
| mem_addr | output | ADDR_W | Stack write address |
| mem_wdata | output | ADDR_W | Stack write data |
| arch_we | output | 1 | Load the new PC, SP and PSW |
| new_pc | output | ADDR_W | Handler address |
| new_sp | output | ADDR_W | Stack pointer after the push |
| new_psw | output | PSW_W | PSW with interrupts masked |

## Verification
The bench goes after fall-through in the priority reduction. Overflow with its enable clear must still let an enabled underflow record U; a design that stops at the first raw flag would record nothing and write the result. It checks that the invalid strobe wins over an enabled overflow and that a disabled divide-by-zero falls through to inexact. It also checks that a disabled FPU outranks an unimplemented opcode; a design that swapped them would report 0x1c8. An operation is issued in the middle of trap entry, where a design that accepted it would pulse a second trap or overwrite the cause. The stacked addresses, the PSW write width and the cleared interrupt bit are checked cycle by cycle.

// File: rtl/fpu_trap_pkg.sv
// Shared constants for the floating-point trap controller.
// Assumes a five-kind cause field and twelve-bit trap vector codes.
package fpu_trap_pkg;
    localparam int CAUSE_W = 5;
    localparam int C_I = 0;
    localparam int C_U = 1;
    localparam int C_O = 2;
    localparam int C_Z = 3;
    localparam int C_V = 4;

    localparam int S_OVF   = 0;
    localparam int S_UNF   = 1;
    localparam int S_DEN   = 2;
    localparam int S_INX   = 3;
    localparam int S_RND   = 4;
    localparam int S_KNOWN = 5;

    localparam int CODE_W = 12;
    localparam logic [CODE_W-1:0] CODE_NONE  = 12'h000;
    localparam logic [CODE_W-1:0] CODE_OFF   = 12'h1c0;
    localparam logic [CODE_W-1:0] CODE_UNIMP = 12'h1c8;
    localparam logic [CODE_W-1:0] CODE_ARITH = 12'h1d0;

    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_PUSH_PC  = 2'd1,
        SQ_PUSH_PSW = 2'd2,
        SQ_JUMP     = 2'd3
    } seq_state_t;
endpackage

// File: rtl/fpu_cause_eval.sv
// Combinational cause reduction for one floating-point operation.
// Order of precedence: invalid, divide-by-zero, overflow, underflow or
// denormal, inexact or rounded. Every kind is gated by its enable bit.
// Assumes STAT_W >= S_KNOWN; bits above the known kinds are only flagged.
module fpu_cause_eval
    import fpu_trap_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic [STAT_W-1:0]  raw_status,
    input  logic               invalid_op,
    input  logic               div_zero,
    input  logic [CAUSE_W-1:0] enable,
    output logic [CAUSE_W-1:0] cause,
    output logic               bad_status
);
    // Reduce the inputs to at most one recorded cause.
    always_comb begin
        cause = '0;
        if (invalid_op) begin
            cause[C_V] = enable[C_V];
        end else if (div_zero && enable[C_Z]) begin
            cause[C_Z] = 1'b1;
        end else if (raw_status[S_OVF] && enable[C_O]) begin
            cause[C_O] = 1'b1;
        end else if ((raw_status[S_UNF] || raw_status[S_DEN]) && enable[C_U]) begin
            cause[C_U] = 1'b1;
        end else if ((raw_status[S_INX] || raw_status[S_RND]) && enable[C_I]) begin
            cause[C_I] = 1'b1;
        end
    end

    generate
        if (STAT_W > S_KNOWN) begin : g_extra
            // Flag any status bit outside the known kinds.
            always_comb bad_status = |raw_status[STAT_W-1:S_KNOWN];
        end else begin : g_exact
            // No unknown bits exist at this width.
            always_comb bad_status = 1'b0;
        end
    endgenerate

    // R2
    always_comb begin
        single_cause_chk: assert ($onehot0(cause));
    end
endmodule

// File: rtl/fpu_trap_seq.sv
// Trap entry sequencer: on start it captures PC, SP and PSW. It then
// pushes the PC (word) to SP-4 and the PSW (half) to SP-8. Last it
// presents the new SP, the masked PSW and the handler PC for one cycle.
// Assumes start is only pulsed while busy is low.
module fpu_trap_seq
    import fpu_trap_pkg::*;
#(
    parameter int              ADDR_W  = 32,
    parameter int              PSW_W   = 16,
    parameter int              IE_BIT  = 11,
    parameter logic [ADDR_W-1:0] HANDLER = 32'h4000_0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [PSW_W-1:0]  psw_in,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              arch_we,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_sp,
    output logic [PSW_W-1:0]  new_psw
);
    localparam logic [ADDR_W-1:0] PC_OFS  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] PSW_OFS = ADDR_W'(8);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] sp_q;
    logic [PSW_W-1:0]  psw_q;

    // Advance through the push and redirect steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            case (state_q)
                SQ_IDLE:     if (start) state_q <= SQ_PUSH_PC;
                SQ_PUSH_PC:  state_q <= SQ_PUSH_PSW;
                SQ_PUSH_PSW: state_q <= SQ_JUMP;
                default:     state_q <= SQ_IDLE;
            endcase
        end
    end

    // Capture the architectural state at the trap edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            sp_q  <= '0;
            psw_q <= '0;
        end else if (start && state_q == SQ_IDLE) begin
            pc_q  <= pc_in;
            sp_q  <= sp_in;
            psw_q <= psw_in;
        end
    end

    // Drive the stack write port from the current step.
    always_comb begin
        mem_we    = (state_q == SQ_PUSH_PC) || (state_q == SQ_PUSH_PSW);
        mem_word  = (state_q == SQ_PUSH_PC);
        mem_addr  = mem_word ? (sp_q - PC_OFS) : (sp_q - PSW_OFS);
        mem_wdata = mem_word ? pc_q : ADDR_W'(psw_q);
        if (!mem_we) begin
            mem_addr  = '0;
            mem_wdata = '0;
        end
    end

    // Present the redirect values.
    always_comb begin
        arch_we         = (state_q == SQ_JUMP);
        new_pc          = HANDLER;
        new_sp          = sp_q - PSW_OFS;
        new_psw         = psw_q;
        new_psw[IE_BIT] = 1'b0;
        busy            = (state_q != SQ_IDLE);
    end

    // R7
    word_then_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_word) |=> (mem_we && !mem_word));
    // R7
    sp_matches_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_word) |=> (arch_we && new_sp == $past(mem_addr)));
    // R7
    ie_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arch_we |-> !new_psw[IE_BIT]);
endmodule

// File: rtl/fpu_trap_ctrl.sv
// Floating-point exception cause and trap controller. Holds the enable
// and cause fields, decides result writes, chooses the trap code and
// starts the trap entry sequencer.
// Assumes op_valid is a one-cycle strobe with all per-op inputs valid.
module fpu_trap_ctrl
    import fpu_trap_pkg::*;
#(
    parameter int                STAT_W  = 8,
    parameter int                ADDR_W  = 32,
    parameter int                PSW_W   = 16,
    parameter int                IE_BIT  = 11,
    parameter logic [ADDR_W-1:0] HANDLER = 32'h4000_0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              fpu_en,
    input  logic              unimpl_op,
    input  logic [STAT_W-1:0] raw_status,
    input  logic              invalid_op,
    input  logic              div_zero,
    output logic              res_we,
    output logic              res_qnan,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [4:0]        reg_wdata,
    output logic [4:0]        reg_rdata,
    output logic              trap_req,
    output logic [11:0]       trap_code,
    input  logic              trap_ack,
    output logic              internal_err,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [PSW_W-1:0]  psw_in,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              arch_we,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_sp,
    output logic [PSW_W-1:0]  new_psw
);
    logic [CAUSE_W-1:0] enable_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] cause_new;
    logic               bad_status;
    logic               busy;
    logic               accept;
    logic               arith_go;
    logic [CODE_W-1:0]  code_sel;
    logic               take_trap;

    fpu_cause_eval #(.STAT_W(STAT_W)) u_eval (
        .raw_status (raw_status),
        .invalid_op (invalid_op),
        .div_zero   (div_zero),
        .enable     (enable_q),
        .cause      (cause_new),
        .bad_status (bad_status)
    );

    fpu_trap_seq #(
        .ADDR_W  (ADDR_W),
        .PSW_W   (PSW_W),
        .IE_BIT  (IE_BIT),
        .HANDLER (HANDLER)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (take_trap),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .psw_in    (psw_in),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_word  (mem_word),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .arch_we   (arch_we),
        .new_pc    (new_pc),
        .new_sp    (new_sp),
        .new_psw   (new_psw)
    );

    // Decide acceptance, trap code and the result write permission.
    always_comb begin
        accept   = op_valid && !busy;
        arith_go = fpu_en && !unimpl_op;
        if (!fpu_en)
            code_sel = CODE_OFF;
        else if (unimpl_op)
            code_sel = CODE_UNIMP;
        else if (cause_new != '0)
            code_sel = CODE_ARITH;
        else
            code_sel = CODE_NONE;
        take_trap = accept && (code_sel != CODE_NONE);
        res_we    = accept && arith_go && (cause_new == '0);
        res_qnan  = res_we && invalid_op;
        reg_rdata = reg_sel ? cause_q : enable_q;
    end

    // Hold the enable field written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (reg_we && !reg_sel)
            enable_q <= reg_wdata;
    end

    // Replace the cause field per operation, else take software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= '0;
        else if (accept && arith_go)
            cause_q <= cause_new;
        else if (reg_we && reg_sel)
            cause_q <= reg_wdata;
    end

    // Pulse the request, hold the code until acknowledged, flag unknown status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req     <= 1'b0;
            trap_code    <= CODE_NONE;
            internal_err <= 1'b0;
        end else begin
            trap_req     <= take_trap;
            internal_err <= accept && arith_go && bad_status;
            if (take_trap)
                trap_code <= code_sel;
            else if (trap_ack)
                trap_code <= CODE_NONE;
        end
    end

    // R3
    res_we_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |=> (cause_q == '0));
    // R5
    arith_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_code == CODE_ARITH) |-> (cause_q != '0));
    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && op_valid) |=> (!trap_req && $stable(cause_q)));
    // R8
    code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_code != CODE_NONE && !trap_ack && !take_trap) |=> $stable(trap_code));
endmodule

// File: tb/fpu_trap_ctrl_test.sv
module fpu_trap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, fpu_en = 1'b0, unimpl_op = 1'b0;
    logic [7:0]  raw_status = '0;
    logic        invalid_op = 1'b0, div_zero = 1'b0;
    logic        res_we, res_qnan;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [4:0]  reg_wdata = '0, reg_rdata;
    logic        trap_req;
    logic [11:0] trap_code;
    logic        trap_ack = 1'b0;
    logic        internal_err;
    logic [31:0] pc_in = 32'h1234_5678, sp_in = 32'h0000_8000;
    logic [15:0] psw_in = 16'h0F00;
    logic        mem_we, mem_word, arch_we;
    logic [31:0] mem_addr, mem_wdata, new_pc, new_sp;
    logic [15:0] new_psw;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpu_trap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .fpu_en(fpu_en),
        .unimpl_op(unimpl_op), .raw_status(raw_status), .invalid_op(invalid_op),
        .div_zero(div_zero), .res_we(res_we), .res_qnan(res_qnan),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trap_req(trap_req), .trap_code(trap_code),
        .trap_ack(trap_ack), .internal_err(internal_err), .pc_in(pc_in),
        .sp_in(sp_in), .psw_in(psw_in), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .arch_we(arch_we),
        .new_pc(new_pc), .new_sp(new_sp), .new_psw(new_psw)
    );

    typedef struct packed {
        logic        fen;
        logic        unimp;
        logic        inv;
        logic        dz;
        logic [7:0]  st;
        logic [4:0]  ena;
        logic [4:0]  cause;
        logic        we;
        logic        qn;
        logic        tr;
        logic [11:0] code;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,8'h00,5'h1f,5'h00,1'b1,1'b0,1'b0,12'h000},
        '{1'b0,1'b0,1'b0,1'b0,8'h00,5'h1f,5'h00,1'b0,1'b0,1'b1,12'h1c0},
        '{1'b1,1'b1,1'b0,1'b0,8'h00,5'h1f,5'h00,1'b0,1'b0,1'b1,12'h1c8},
        '{1'b0,1'b1,1'b0,1'b0,8'h00,5'h1f,5'h00,1'b0,1'b0,1'b1,12'h1c0},
        '{1'b1,1'b0,1'b0,1'b0,8'h19,5'h1f,5'h04,1'b0,1'b0,1'b1,12'h1d0},
        '{1'b1,1'b0,1'b0,1'b0,8'h0a,5'h1f,5'h02,1'b0,1'b0,1'b1,12'h1d0},
        '{1'b1,1'b0,1'b0,1'b0,8'h03,5'h1b,5'h02,1'b0,1'b0,1'b1,12'h1d0},
        '{1'b1,1'b0,1'b0,1'b0,8'h01,5'h1b,5'h00,1'b1,1'b0,1'b0,12'h000},
        '{1'b1,1'b0,1'b0,1'b0,8'h10,5'h01,5'h01,1'b0,1'b0,1'b1,12'h1d0},
        '{1'b1,1'b0,1'b0,1'b0,8'h04,5'h00,5'h00,1'b1,1'b0,1'b0,12'h000},
        '{1'b1,1'b0,1'b1,1'b0,8'h00,5'h10,5'h10,1'b0,1'b0,1'b1,12'h1d0},
        '{1'b1,1'b0,1'b1,1'b0,8'h01,5'h0f,5'h00,1'b1,1'b1,1'b0,12'h000},
        '{1'b1,1'b0,1'b0,1'b1,8'h08,5'h01,5'h01,1'b0,1'b0,1'b1,12'h1d0},
        '{1'b1,1'b0,1'b0,1'b1,8'h00,5'h08,5'h08,1'b0,1'b0,1'b1,12'h1d0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_enable(input logic [4:0] e);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = e;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic drive_op(input logic fe, input logic un, input logic inv,
                            input logic dz, input logic [7:0] st);
        op_valid = 1'b1; fpu_en = fe; unimpl_op = un;
        invalid_op = inv; div_zero = dz; raw_status = st;
    endtask

    task automatic clear_op();
        op_valid = 1'b0; fpu_en = 1'b1; unimpl_op = 1'b0;
        invalid_op = 1'b0; div_zero = 1'b0; raw_status = '0;
    endtask

    task automatic finish_trap(input logic [11:0] code);
        repeat (3) @(negedge clk);
        #1 chk(trap_code == code, "R8 held", 32'(trap_code), 32'(code));
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
        #1 chk(trap_code == 12'h000, "R8 ack", 32'(trap_code), 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        reg_sel = 1'b0;
        #1 chk(reg_rdata == 5'h00, "R11 enable", 32'(reg_rdata), 0);
        reg_sel = 1'b1;
        #1 chk(reg_rdata == 5'h00, "R11 cause", 32'(reg_rdata), 0);
        chk(!trap_req && trap_code == 0 && !mem_we && !arch_we && !internal_err,
            "R11 outputs", {trap_req, trap_code, mem_we, arch_we, internal_err}, 0);

        // Vector table: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            set_enable(VEC[i].ena);
            @(negedge clk);
            drive_op(VEC[i].fen, VEC[i].unimp, VEC[i].inv, VEC[i].dz, VEC[i].st);
            #1 chk(res_we == VEC[i].we, "R3 res_we", 32'(res_we), 32'(VEC[i].we));
            chk(res_qnan == VEC[i].qn, "R4 qnan", 32'(res_qnan), 32'(VEC[i].qn));
            @(negedge clk);
            clear_op();
            reg_sel = 1'b1;
            #1 chk(reg_rdata == VEC[i].cause, "R1/R2 cause", 32'(reg_rdata), 32'(VEC[i].cause));
            chk(trap_req == VEC[i].tr, "R5/R6 req", 32'(trap_req), 32'(VEC[i].tr));
            chk(trap_code == VEC[i].code, "R5/R6 code", 32'(trap_code), 32'(VEC[i].code));
            if (VEC[i].tr) finish_trap(VEC[i].code);
        end

        // R7 trap entry sequence, R9 op ignored mid-sequence
        set_enable(5'h1f);
        @(negedge clk);
        drive_op(1'b1, 1'b0, 1'b0, 1'b0, 8'h01);
        @(negedge clk);
        clear_op();
        #1 chk(mem_we && mem_word && mem_addr == 32'h7FFC && mem_wdata == 32'h1234_5678,
               "R7 push pc", mem_addr, 32'h7FFC);
        drive_op(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        #1 chk(!res_we, "R9 no write", 32'(res_we), 0);
        @(negedge clk);
        clear_op();
        #1 chk(mem_we && !mem_word && mem_addr == 32'h7FF8 && mem_wdata == 32'h0000_0F00,
               "R7 push psw", mem_wdata, 32'h0F00);
        chk(!trap_req, "R9 no retrap", 32'(trap_req), 0);
        reg_sel = 1'b1;
        #1 chk(reg_rdata == 5'h04, "R9 cause kept", 32'(reg_rdata), 32'h04);
        @(negedge clk);
        #1 chk(arch_we && !mem_we && new_pc == 32'h4000_0008, "R7 new pc", new_pc, 32'h4000_0008);
        chk(new_sp == 32'h7FF8, "R7 new sp", new_sp, 32'h7FF8);
        chk(new_psw == 16'h0700, "R7 new psw", 32'(new_psw), 32'h0700);
        @(negedge clk);
        #1 chk(!arch_we && !mem_we, "R7 idle", {arch_we, mem_we}, 0);
        chk(trap_code == 12'h1d0, "R8 held long", 32'(trap_code), 32'h1d0);
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
        #1 chk(trap_code == 0, "R8 cleared", 32'(trap_code), 0);

        // R10 unknown status bit
        set_enable(5'h00);
        @(negedge clk);
        drive_op(1'b1, 1'b0, 1'b0, 1'b0, 8'h40);
        #1 chk(res_we, "R10 write", 32'(res_we), 1);
        @(negedge clk);
        clear_op();
        #1 chk(internal_err, "R10 flag", 32'(internal_err), 1);
        chk(!trap_req, "R10 no trap", 32'(trap_req), 0);
        @(negedge clk);
        #1 chk(!internal_err, "R10 pulse", 32'(internal_err), 0);

        // R11 register port: op wins over same-edge cause write
        set_enable(5'h01);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 5'h1e;
        drive_op(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        reg_we = 1'b0;
        clear_op();
        #1 chk(reg_rdata == 5'h00, "R11 op wins", 32'(reg_rdata), 0);
        reg_sel = 1'b0;
        #1 chk(reg_rdata == 5'h01, "R11 enable read", 32'(reg_rdata), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule